// File: doc/BRIEF.md
# Pulse-Swallow Frequency Divider

This block sits behind a dual-modulus prescaler in a frequency synthesizer loop. Its clock is the prescaler's output, and it holds two down-counters on that clock. The main counter sets how many prescaler pulses make one output period. The swallow counter sets how many of those pulses come from the prescaler running at its higher modulus. While the swallow counter is non-zero, the block raises a modulus-select output that tells the prescaler to divide by P+1. When the swallow counter reaches zero it stays there, and the prescaler divides by P until the period ends. The overall ratio from the prescaler input to the block output is therefore P·N + A.

Software writes the two ratio values into a holding latch outside this block, and the block reads them only at period boundaries. A main ratio below the legal minimum is raised to that minimum. A swallow ratio larger than the main ratio is lowered to match it. A small state machine keeps the mode. It has three states:
- **START**: entered on reset; nothing is driven.
- **SWALLOW**: modulus select is high.
- **MAIN**: modulus select is low.

It has four transitions:
- **START→load**: the first edge after reset loads both counters.
- **SWALLOW→MAIN on swallow done**: the swallow counter is about to reach zero.
- **any→load on period end**: the main counter is at one, which reloads both counters and enters SWALLOW, or enters MAIN if the swallow ratio is zero.
- **hold**: any other case.

Top module: `swallow_divider`

## Requirements
- R1: While reset is low, `mod_hi` and `div_pulse` are 0. The first divide period begins at the first rising clock edge after reset is released.
- R2: `div_pulse` is high for exactly one clock once every Neff clocks, where Neff is the effective main ratio. It is high on the last clock of each period.
- R3: `mod_hi` is 1 for the first Aeff clocks of each period and 0 for the rest. It never rises in the middle of a period.
- R4: When the swallow ratio is 0, `mod_hi` stays 0 for the whole period.
- R5: When the swallow ratio is greater than Neff, Aeff equals Neff, so `mod_hi` stays 1 for the whole period.
- R6: A main ratio below 16 (including 0) is handled as 16.
- R7: Both ratio inputs are sampled only at the clock edge that ends a `div_pulse` clock, or at the first edge after reset. Changes at any other time have no effect on the period in progress.
- R8: The full ranges work, including main ratio 2047 with swallow ratio 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swallow_in | input | 7 | Latched swallow ratio A |
| count_in | input | 11 | Latched main ratio N |
| mod_hi | output | 1 | 1 selects prescaler modulus P+1, 0 selects P |
| div_pulse | output | 1 | One-clock pulse at the end of each period |

## Verification
On every cycle, the assertions check four things:
- the mode state agrees with the swallow count;
- `mod_hi` never rises inside a period;
- the swallow counter holds at zero;
- each load leaves the main counter at or above the minimum, and the clamped swallow ratio never exceeds the main ratio.

Only the bench scenarios can show the exact period length and the exact position of the modulus edge for a given input pair. The same is true of the clamp values and of inputs changed mid-period being ignored until the boundary. The bench measures these period by period across a sweep of ratio pairs.

// File: rtl/swallow_divider_pkg.sv
package swallow_divider_pkg;

    typedef enum logic [1:0] {
        ST_START   = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } sd_state_t;

endpackage

// File: rtl/sd_ratio_guard.sv
module sd_ratio_guard #(
    parameter int SW_W   = 7,
    parameter int PG_W   = 11,
    parameter int PG_MIN = 16
) (
    input  logic [SW_W-1:0] a_raw,
    input  logic [PG_W-1:0] n_raw,
    output logic [SW_W-1:0] a_eff,
    output logic [PG_W-1:0] n_eff
);
    localparam logic [PG_W-1:0] N_FLOOR = PG_W'(PG_MIN);

    logic [PG_W-1:0] a_wide;

    always_comb begin
        a_wide = PG_W'(a_raw);
        // Main ratio below the legal floor is raised to the floor.
        n_eff  = (n_raw < N_FLOOR) ? N_FLOOR : n_raw;
        // Swallow ratio may not exceed the main ratio.
        if (a_wide > n_eff) begin
            a_eff = SW_W'(n_eff);
        end else begin
            a_eff = a_raw;
        end
    end

    always_comb begin
        p_clamp_bound_r5: assert (PG_W'(a_eff) <= n_eff)
            else $error("clamped swallow exceeds main ratio");
    end

endmodule

// File: rtl/sd_swallow_ctr.sv
module sd_swallow_ctr #(
    parameter int SW_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SW_W-1:0] ld_val,
    output logic [SW_W-1:0] cnt,
    output logic            at_one
);
    localparam logic [SW_W-1:0] ONE = SW_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= ld_val;
        end else if (cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign at_one = (cnt == ONE);

    // Once drained, the swallow counter holds at zero until the next load.
    p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/sd_main_ctr.sv
module sd_main_ctr #(
    parameter int PG_W   = 11,
    parameter int PG_MIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PG_W-1:0] ld_val,
    output logic [PG_W-1:0] cnt,
    output logic            at_one
);
    localparam logic [PG_W-1:0] ONE = PG_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= ld_val;
        end else if (cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign at_one = (cnt == ONE);

    p_load_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt >= PG_W'(PG_MIN)));

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import swallow_divider_pkg::*;
#(
    parameter int SW_W   = 7,
    parameter int PG_W   = 11,
    parameter int PG_MIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW_W-1:0] swallow_in,
    input  logic [PG_W-1:0] count_in,
    output logic            mod_hi,
    output logic            div_pulse
);
    sd_state_t       state_q;
    sd_state_t       state_d;
    logic [SW_W-1:0] a_eff;
    logic [PG_W-1:0] n_eff;
    logic [SW_W-1:0] s_cnt;
    logic [PG_W-1:0] p_cnt;
    logic            s_one;
    logic            p_one;
    logic            load;

    sd_ratio_guard #(
        .SW_W  (SW_W),
        .PG_W  (PG_W),
        .PG_MIN(PG_MIN)
    ) u_guard (
        .a_raw(swallow_in),
        .n_raw(count_in),
        .a_eff(a_eff),
        .n_eff(n_eff)
    );

    // A load happens after reset and at the edge that closes each period.
    assign load = (state_q == ST_START) || p_one;

    sd_swallow_ctr #(
        .SW_W(SW_W)
    ) u_swallow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .ld_val(a_eff),
        .cnt   (s_cnt),
        .at_one(s_one)
    );

    sd_main_ctr #(
        .PG_W  (PG_W),
        .PG_MIN(PG_MIN)
    ) u_main (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .ld_val(n_eff),
        .cnt   (p_cnt),
        .at_one(p_one)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_START: begin
                state_d = (a_eff != '0) ? ST_SWALLOW : ST_MAIN;
            end
            ST_SWALLOW: begin
                if (p_one) begin
                    state_d = (a_eff != '0) ? ST_SWALLOW : ST_MAIN;
                end else if (s_one) begin
                    state_d = ST_MAIN;
                end
            end
            ST_MAIN: begin
                if (p_one) begin
                    state_d = (a_eff != '0) ? ST_SWALLOW : ST_MAIN;
                end
            end
            default: state_d = ST_START;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_START;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        mod_hi    = 1'b0;
        div_pulse = 1'b0;
        unique case (state_q)
            ST_START:   begin mod_hi = 1'b0; div_pulse = 1'b0;  end
            ST_SWALLOW: begin mod_hi = 1'b1; div_pulse = p_one; end
            ST_MAIN:    begin mod_hi = 1'b0; div_pulse = p_one; end
            default:    begin mod_hi = 1'b0; div_pulse = 1'b0;  end
        endcase
    end

    // Mode state tracks the swallow count once running.
    p_mode_matches_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_START) |-> (mod_hi == (s_cnt != '0)));

    // The modulus select never rises inside a period.
    p_no_mid_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_START && !mod_hi && !div_pulse) |=> !mod_hi);

    // The period pulse lasts one clock.
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    // The main counter never sits at zero once running.
    p_main_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_START) |-> (p_cnt != '0));

endmodule

// File: tb/swallow_divider_test.sv
module swallow_divider_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  swallow_in = '0;
    logic [10:0] count_in = '0;
    logic        mod_hi;
    logic        div_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    swallow_divider uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .swallow_in(swallow_in),
        .count_in  (count_in),
        .mod_hi    (mod_hi),
        .div_pulse (div_pulse)
    );

    function automatic int eff_n(int n);
        return (n < 16) ? 16 : n;
    endfunction

    function automatic int eff_a(int a, int n);
        int ne = eff_n(n);
        return (a > ne) ? ne : a;
    endfunction

    function automatic string tag_for(int a, int n);
        if (n < 16)        return "R6";
        if (n == 2047)     return "R8";
        if (a == 0)        return "R4";
        if (a > n)         return "R5";
        return "R3";
    endfunction

    // Measure one period that starts right after a pulse sample; at sample
    // index 2 drive the next ratio pair (must not affect this period).
    task automatic run_cycle(input int exp_n, input int exp_a, input string tg,
                             input int nxt_n, input int nxt_a);
        int k = 0;
        int bad_k = -1;
        bit got_mod = 0;
        bit seen = 0;
        while (!seen && k < 4200) begin
            @(negedge clk);
            if (mod_hi !== (k < exp_a) && bad_k < 0) begin
                bad_k = k;
                got_mod = mod_hi;
            end
            if (k == 2) begin
                swallow_in = 7'(nxt_a);
                count_in   = 11'(nxt_n);
            end
            seen = (div_pulse === 1'b1);
            k++;
        end
        checks++;
        if (k != exp_n) begin
            fails++;
            $display("FAIL R2 R7 period length: actual %0d expected %0d", k, exp_n);
        end
        checks++;
        if (bad_k >= 0) begin
            fails++;
            $display("FAIL %s R3 R7 mod_hi at clock %0d: actual %0b expected %0b (A=%0d N=%0d)",
                     tg, bad_k, got_mod, !got_mod, exp_a, exp_n);
        end
    endtask

    initial begin
        int pn;
        int pa;
        int an [7];
        swallow_in = 7'd5;
        count_in   = 11'd20;
        repeat (3) @(negedge clk);
        checks++;
        if (mod_hi !== 1'b0 || div_pulse !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs: actual %0b%0b expected 00", mod_hi, div_pulse);
        end
        rst_n = 1'b1;
        // First period starts at the next rising edge (R1).
        pn = 20; pa = 5;
        for (int n = 16; n <= 40; n += 4) begin
            an = '{0, 1, n / 2, n - 1, n, n + 1, 127};
            for (int i = 0; i < 7; i++) begin
                run_cycle(eff_n(pn), eff_a(pa, pn), tag_for(pa, pn), n, an[i]);
                pn = n; pa = an[i];
            end
        end
        run_cycle(eff_n(pn), eff_a(pa, pn), tag_for(pa, pn), 5, 3);
        pn = 5; pa = 3;
        run_cycle(eff_n(pn), eff_a(pa, pn), tag_for(pa, pn), 0, 0);
        pn = 0; pa = 0;
        run_cycle(eff_n(pn), eff_a(pa, pn), tag_for(pa, pn), 127, 127);
        pn = 127; pa = 127;
        run_cycle(eff_n(pn), eff_a(pa, pn), tag_for(pa, pn), 2047, 127);
        pn = 2047; pa = 127;
        run_cycle(eff_n(pn), eff_a(pa, pn), tag_for(pa, pn), 16, 16);
        pn = 16; pa = 16;
        run_cycle(eff_n(pn), eff_a(pa, pn), tag_for(pa, pn), 17, 0);
        pn = 17; pa = 0;
        run_cycle(eff_n(pn), eff_a(pa, pn), tag_for(pa, pn), 17, 0);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule